// File: doc/BRIEF.md
# Serial Configuration Write Port With Descending Address Streaming

This block is a write-only, three-wire serial slave that fills a byte-wide configuration register file. Its three inputs are a serial clock, serial data and a latch-enable line. Latch-enable is held low for the whole transfer. The transfer opens with a 16-bit header word, sent most significant bit first. The low 15 bits of the header give the register address and the top bit is ignored. After the header come data bytes. The first complete byte lands at the header address. Each further complete byte lands one address lower, so a long stream fills a descending run of registers. The transfer ends when latch-enable rises.

The serial logic runs on the serial clock. Each finished byte is handed to the system clock domain through a toggle handshake, and the register file is written and read there. Every register has its own power-on value. A software reset bit inside the file restores all of those values. A write to the divider low byte at address 16 raises a one-cycle start pulse, which downstream logic uses to launch its sequence. Other chip logic reads any register through a registered read port.

Top module: `cfg_serial_slave`

## Requirements
- R1: A frame shifts bits in on rising serial clock edges while latch-enable is low, most significant bit first. The frame is a 16-bit header whose low 15 bits are the address, with bit 15 ignored, followed by a data byte that is written to that address.
- R2: Each further complete 8-bit byte in the same frame is written to the address one below that of the previous byte.
- R3: A byte with fewer than 8 bits received when latch-enable rises is discarded. The next frame starts again with a fresh 16-bit header.
- R4: After the synchronous reset, every register reads 0x00 except these: 0=0x18, 16=0x64, 25=0x04, 27=0x08, 30=0x0A, 31=0x32, 33=0x0F, 35=0x41, 36=0x08, 37=0x10, 38=0x18, 39=0x38, 70=0x08, and 79 to 82=0xFF.
- R5: Writing register 2 with bit 2 set restores every register to its R4 value, and register 2 then reads 0x00. Writing register 2 with bit 2 clear simply stores the byte.
- R6: `start_pulse` is high for exactly one system clock cycle after each write to register 16, and never after writes to other addresses.
- R7: Each committed serial byte causes exactly one register write in the system clock domain. This holds when each serial clock phase lasts at least 2 system clock periods.
- R8: `rd_data` returns the register at `rd_addr` one cycle later. Addresses of 142 and above read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sle | input | 1 | Latch-enable; low during a frame, rising ends it |
| sdi | input | 1 | Serial data, MSB first |
| rd_addr | input | 15 | Register read address |
| rd_data | output | 8 | Registered read data |
| start_pulse | output | 1 | One-cycle pulse after a write to register 16 |

## Verification
The hardest situations to reach from the ports are a stream that walks the address downward across the top edge of the populated file, and a soft reset landing in the middle of a frame. The stimulus covers the first with a frame that starts above the last register and streams down into it. It covers the second with a write to register 2 whose bit 2 is set, which must undo earlier writes. A frame cut off mid-byte is followed at once by a new frame, to show that the leftover bits neither commit nor corrupt the next header. A behavioural model is updated per frame and compared against a read sweep on every quiet clock.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int unsigned SWR_ADDR   = 2;
  localparam int unsigned SWR_BIT    = 2;
  localparam int unsigned START_ADDR = 16;

  // power-on value of each register
  function automatic logic [7:0] reg_default(input int a);
    case (a)
      0:  return 8'h18;
      16: return 8'h64;
      25: return 8'h04;
      27: return 8'h08;
      30: return 8'h0A;
      31: return 8'h32;
      33: return 8'h0F;
      35: return 8'h41;
      36: return 8'h08;
      37: return 8'h10;
      38: return 8'h18;
      39: return 8'h38;
      70: return 8'h08;
      79, 80, 81, 82: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              sclk,
  input  logic              sle,
  input  logic              sdi,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              tog
);
  localparam int HDR_W = ADDR_W + 1;
  localparam int CNT_W = $clog2(HDR_W + 1);
  localparam int BIT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  hdr_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [HDR_W-1:0]  sh;
  logic [ADDR_W-1:0] cur_addr;
  logic              hdr_done, byte_last;
  logic              tog_q = 1'b0;

  assign hdr_done  = (hdr_cnt == CNT_W'(HDR_W));
  assign byte_last = hdr_done && (bit_cnt == BIT_W'(DATA_W - 1));
  assign tog       = tog_q;

  // frame state, cleared while latch-enable is high
  always_ff @(posedge sclk or posedge sle) begin
    if (sle) begin
      hdr_cnt  <= '0;
      bit_cnt  <= '0;
      sh       <= '0;
      cur_addr <= '0;
    end else begin
      sh <= {sh[HDR_W-2:0], sdi};
      if (!hdr_done) begin
        hdr_cnt <= hdr_cnt + CNT_W'(1);
        if (hdr_cnt == CNT_W'(HDR_W - 1))
          cur_addr <= {sh[ADDR_W-2:0], sdi};
      end else begin
        bit_cnt <= byte_last ? '0 : bit_cnt + BIT_W'(1);
        if (byte_last)
          cur_addr <= cur_addr - ADDR_W'(1);
      end
    end
  end

  // completed byte: hold it and flip the handshake toggle
  always_ff @(posedge sclk) begin
    if (byte_last) begin
      hold_addr <= cur_addr;
      hold_data <= {sh[DATA_W-2:0], sdi};
      tog_q     <= ~tog_q;
    end
  end
endmodule

// File: rtl/cfg_serial_xing.sv
module cfg_serial_xing #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tog,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic [DATA_W-1:0] hold_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int STG = SYNC_N + 1;

  logic [STG-1:0] sync;
  logic           pulse;

  assign pulse = sync[STG-1] ^ sync[STG-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sync  <= {sync[STG-2:0], tog};
      wr_en <= pulse;
      if (pulse) begin
        wr_addr <= hold_addr;
        wr_data <= hold_data;
      end
    end
  end
endmodule

// File: rtl/cfg_serial_regs.sv
module cfg_serial_regs
  import cfg_serial_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int NREGS  = 142
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              start_pulse
);
  localparam int IDX_W = $clog2(NREGS);

  logic [DATA_W-1:0] mem [NREGS];
  logic              w_in, r_in, swr;

  assign w_in = wr_addr < ADDR_W'(NREGS);
  assign r_in = rd_addr < ADDR_W'(NREGS);
  assign swr  = wr_en && (wr_addr == ADDR_W'(SWR_ADDR)) && wr_data[SWR_BIT];

  always_ff @(posedge clk) begin
    if (rst || swr) begin
      for (int i = 0; i < NREGS; i++)
        mem[i] <= DATA_W'(reg_default(i));
    end else if (wr_en && w_in) begin
      mem[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      start_pulse <= 1'b0;
    end else begin
      rd_data     <= r_in ? mem[rd_addr[IDX_W-1:0]] : '0;
      start_pulse <= wr_en && (wr_addr == ADDR_W'(START_ADDR));
    end
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int NREGS  = 142
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sle,
  input  logic              sdi,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              start_pulse
);
  logic [ADDR_W-1:0] hold_addr, wr_addr;
  logic [DATA_W-1:0] hold_data, wr_data;
  logic              sr_tog, wr_en;

  cfg_serial_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .sclk(sclk), .sle(sle), .sdi(sdi),
    .hold_addr(hold_addr), .hold_data(hold_data), .tog(sr_tog)
  );

  cfg_serial_xing #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xing (
    .clk(clk), .rst(rst), .tog(sr_tog),
    .hold_addr(hold_addr), .hold_data(hold_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  cfg_serial_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .start_pulse(start_pulse)
  );
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int NREGS  = 142
) (
  input logic              clk,
  input logic              rst,
  input logic              sle,
  input logic              sr_tog,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              start_pulse
);
  p_start_single_r6: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);

  p_start_cause_r6: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> ($past(wr_en) && ($past(wr_addr) == ADDR_W'(16))));

  p_write_single_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  p_oob_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(rd_addr) >= ADDR_W'(NREGS))) |-> (rd_data == '0));

  p_idle_no_commit_r3: assert property (@(posedge clk) disable iff (rst)
    (sle && $past(sle)) |-> $stable(sr_tog));
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)
) u_chk (
  .clk(clk), .rst(rst), .sle(sle), .sr_tog(sr_tog), .wr_en(wr_en),
  .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_data(rd_data),
  .start_pulse(start_pulse)
);

// File: tb/cfg_serial_slave_test.sv
module cfg_serial_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 142;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        sle = 1'b1;
  logic        sdi = 1'b0;
  logic [14:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        start_pulse;

  int model [NR];
  int total = 0, failed = 0;
  int starts_seen = 0, starts_exp = 0;
  bit settled = 0;
  int sweep_idx = 0;

  cfg_serial_slave uut (
    .clk(clk), .rst(rst), .sclk(sclk), .sle(sle), .sdi(sdi),
    .rd_addr(rd_addr), .rd_data(rd_data), .start_pulse(start_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int dflt(input int a);
    if (a == 0) return 'h18;
    if (a == 16) return 'h64;
    if (a == 25 || a == 36) return (a == 25) ? 'h04 : 'h08;
    if (a == 27 || a == 70) return 'h08;
    if (a == 30) return 'h0A;
    if (a == 31) return 'h32;
    if (a == 33) return 'h0F;
    if (a == 35) return 'h41;
    if (a == 37) return 'h10;
    if (a == 38) return 'h18;
    if (a == 39) return 'h38;
    if (a >= 79 && a <= 82) return 'hFF;
    return 0;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < NR; i++) model[i] = dflt(i);
  endfunction

  function automatic int expv(input int a);
    return (a < NR) ? model[a] : 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference comparison on every quiet clock, sweeping the read address
  always @(negedge clk) begin
    if (!rst && settled) begin
      total++;
      if (int'(rd_data) != expv(int'(rd_addr))) begin
        failed++;
        $display("FAIL R8 readback addr=%0d actual=%0h expected=%0h",
                 rd_addr, rd_data, expv(int'(rd_addr)));
      end
    end
    sweep_idx = (sweep_idx + 1) % 154;
    rd_addr = (sweep_idx < 152) ? 15'(sweep_idx) : ((sweep_idx == 152) ? 15'd200 : 15'h7FFF);
  end

  always @(negedge clk) if (start_pulse) starts_seen++;

  task automatic sbit(input logic b);
    @(negedge clk); sdi = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  // hdr: 16-bit header; n bytes taken from the top of d; partial extra bits
  task automatic frame(input int hdr, input int n, input logic [63:0] d, input int partial);
    settled = 0;
    @(negedge clk); sle = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 15; i >= 0; i--) sbit(hdr[i]);
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) sbit(d[63 - 8*k - (7 - b)]);
    for (int p = 0; p < partial; p++) sbit(1'b1);
    @(negedge clk); sle = 1'b1;
    repeat (16) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      int a, v;
      a = ((hdr & 32'h7FFF) - k) & 32'h7FFF;
      v = int'(d[63 - 8*k -: 8]);
      if (a < NR) begin
        if (a == 2 && v[2]) model_reset();
        else model[a] = v;
        if (a == 16) starts_exp++;
      end
    end
    settled = 1;
  endtask

  task automatic chk_reg(input string tag, input int a, input int e);
    for (int t = 0; t < 400; t++) begin
      @(posedge clk); #(CLK_PERIOD/4);
      if (rd_addr == 15'(a)) break;
    end
    check(tag, int'(rd_data), e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    model_reset();
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    settled = 1;

    // R4 reset values
    chk_reg("R4 reg16", 16, 'h64);
    chk_reg("R4 reg25", 25, 'h04);
    chk_reg("R4 reg33", 33, 'h0F);
    chk_reg("R4 reg80", 80, 'hFF);
    chk_reg("R4 reg5", 5, 'h00);
    check("R6 no start after reset", starts_seen, 0);

    // R1 single byte
    frame(25, 1, 64'hA5 << 56, 0);
    chk_reg("R1 reg25", 25, 'hA5);
    check("R6 no start for reg25", starts_seen, 0);

    // R1 top header bit ignored, R2 descending stream through reg16
    frame('h8011, 3, 64'h123456 << 40, 0);
    chk_reg("R2 reg17", 17, 'h12);
    chk_reg("R2 reg16", 16, 'h34);
    chk_reg("R2 reg15", 15, 'h56);
    check("R6 one start for reg16", starts_seen, 1);

    // R3 partial byte discarded, then a fresh frame
    frame(40, 1, 64'h77 << 56, 5);
    chk_reg("R3 reg40", 40, 'h77);
    chk_reg("R3 reg39 untouched", 39, 'h38);
    frame(41, 1, 64'h99 << 56, 0);
    chk_reg("R3 next frame reg41", 41, 'h99);
    chk_reg("R3 reg40 kept", 40, 'h77);

    // R8 out-of-range address and stream crossing the top edge
    frame(200, 1, 64'h55 << 56, 0);
    chk_reg("R8 addr200 reads zero", 200, 0);
    frame(143, 3, 64'hAABBC3 << 40, 0);
    chk_reg("R8 reg141 from edge stream", 141, 'hC3);

    // R2 long stream, R7 one write per byte
    frame(90, 8, 64'h0102030405060708, 0);
    chk_reg("R7 reg90", 90, 'h01);
    chk_reg("R7 reg86", 86, 'h05);
    chk_reg("R7 reg83", 83, 'h08);

    // R6/R7 two writes to reg16 in one frame each
    frame(16, 1, 64'h21 << 56, 0);
    frame(17, 2, 64'h4342 << 48, 0);
    check("R7 start count matches writes", starts_seen, starts_exp);

    // R5 soft reset restores defaults, bit clears itself
    frame(2, 1, 64'h04 << 56, 0);
    chk_reg("R5 reg25 default", 25, 'h04);
    chk_reg("R5 reg16 default", 16, 'h64);
    chk_reg("R5 reg2 cleared", 2, 'h00);
    chk_reg("R5 reg41 default", 41, 'h00);

    // R5 write to reg2 without the reset bit just stores
    frame(25, 1, 64'h11 << 56, 0);
    frame(2, 1, 64'h03 << 56, 0);
    chk_reg("R5 reg2 stored", 2, 'h03);
    chk_reg("R5 reg25 kept", 25, 'h11);
    check("R6 final start count", starts_seen, starts_exp);

    repeat (200) @(negedge clk);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule